// File: doc/BRIEF.md
# Adjustable Time-of-Day Counter

This block keeps a precision time of day as a 32-bit seconds count and a 32-bit nanoseconds count. On every clock cycle the nanoseconds advance by a fixed nominal step. A signed fine-rate setting trims this step. The setting is a sign bit plus a 31-bit magnitude. The magnitude goes into a 32-bit fractional-nanosecond accumulator. Each carry out of the accumulator adds one nanosecond to the step, and each borrow takes one away. When the nanoseconds reach one billion they wrap to the remainder and the seconds go up by one. A maskable single-cycle event marks each wrap and can serve as a pulse-per-second interrupt source.

Software uses a small register bus with four word addresses. It can read the time atomically: a read of the nanoseconds word takes a snapshot of the seconds at that same instant, and a later read of the seconds word returns that snapshot. To set the time, software writes the nanoseconds word (staged) and then the seconds word (commit). The running time is also exported on ports, for the compare and capture logic nearby.

Top module: `tod_clock`

## Requirements
- R1: While reset is high, and on the first edge after it, seconds, nanoseconds, the wrap event, read data and read-valid are all zero. The rate word and the control word read back as zero.
- R2: With a rate magnitude of zero, the nanoseconds grow by exactly NOM_NS on every clock cycle.
- R3: When the current nanoseconds plus the step reach NS_PER_SEC, the nanoseconds become the excess over NS_PER_SEC and the seconds go up by one on the same edge. The nanoseconds stay below NS_PER_SEC.
- R4: The wrap event is high for exactly the one cycle after the edge on which a wrap happened, and only when bit 0 of the control word (address 3) is 1. With that bit at 0 the seconds still roll over, but no event appears.
- R5: The rate word sits at address 2. Bit 31 is the direction: 0 runs fast, 1 runs slow. Bits 30:0 are the magnitude. Each cycle the magnitude is added to the 32-bit fraction (fast) or subtracted from it (slow). A carry raises that cycle's step by one; a borrow lowers it by one.
- R6: Every magnitude up to 2^31-1 is exact. This includes 858,993,445, the value for the largest correction the block must support.
- R7: A read of address 0 returns the nanoseconds and captures the seconds of the same instant. A read of address 1 returns that captured value, not the live seconds.
- R8: A write to address 0 only stages a nanoseconds value; the running time is unchanged. A write to address 1 loads the written seconds and the staged nanoseconds on that edge, and clears the fraction.
- R9: Read data and a one-cycle read-valid appear on the edge after the edge that samples a read. The rate and control words read back what was written.
- R10: `tod_time` always equals seconds in bits 63:32 and nanoseconds in bits 31:0, and matches `tod_sec` and `tod_nsec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address: 0 nanoseconds, 1 seconds, 2 rate, 3 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle |
| tod_sec | output | 32 | Running seconds |
| tod_nsec | output | 32 | Running nanoseconds |
| tod_time | output | 64 | Seconds and nanoseconds combined |
| wrap_evt | output | 1 | Once-per-second wrap event |

## Verification
The hardest case to reach from the ports is a wrap that falls between the two halves of a time read, since a real second takes a billion nanoseconds. The stimulus avoids that wait: it commits a time a few tens of nanoseconds below the wrap, reads the nanoseconds word, idles past the wrap, and only then reads the seconds word, which must still return the pre-wrap second. Fractional carries and borrows are checked against a closed-form count: after n cycles from a commit, the number of carries or borrows is the floor or ceiling of n times the magnitude over 2^32. A second commit made while the fraction is non-zero shows whether the fraction is cleared.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    REG_NSEC = 2'd0,
    REG_SEC  = 2'd1,
    REG_RATE = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic        slow;
    logic [30:0] mag;
  } rate_t;

endpackage

// File: rtl/tod_frac_step.sv
module tod_frac_step
  import tod_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 32,
  parameter int NOM_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  rate_t             rate,
  output logic [DATA_W-1:0] step
);

  localparam int MAG_W = $bits(rate.mag);
  localparam logic [DATA_W-1:0] NOM = DATA_W'(NOM_NS);

  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   mag_ext;
  logic [FRAC_W:0]   sum_up;
  logic [FRAC_W:0]   sum_dn;
  logic              carry;
  logic              borrow;

  always_comb begin
    mag_ext = {{(FRAC_W + 1 - MAG_W){1'b0}}, rate.mag};
    sum_up  = {1'b0, frac_q} + mag_ext;
    sum_dn  = {1'b0, frac_q} - mag_ext;
    carry   = sum_up[FRAC_W];
    borrow  = sum_dn[FRAC_W];
    if (rate.slow) step = NOM - DATA_W'(borrow);
    else           step = NOM + DATA_W'(carry);
  end

  always_ff @(posedge clk) begin
    if (rst || clear)   frac_q <= '0;
    else if (rate.slow) frac_q <= sum_dn[FRAC_W-1:0];
    else                frac_q <= sum_up[FRAC_W-1:0];
  end

endmodule

// File: rtl/tod_core.sv
module tod_core #(
  parameter int          DATA_W     = 32,
  parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] commit_ns,
  input  logic [DATA_W-1:0] commit_sec,
  input  logic [DATA_W-1:0] step,
  input  logic              pulse_en,
  output logic [DATA_W-1:0] sec_q,
  output logic [DATA_W-1:0] ns_q,
  output logic              wrap_q
);

  localparam logic [DATA_W:0] LIM = (DATA_W + 1)'(NS_PER_SEC);

  logic [DATA_W:0] sum;
  logic [DATA_W:0] nxt;
  logic            roll;

  always_comb begin
    sum  = {1'b0, ns_q} + {1'b0, step};
    roll = (sum >= LIM);
    nxt  = roll ? (sum - LIM) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      ns_q   <= '0;
      wrap_q <= 1'b0;
    end else if (commit) begin
      sec_q  <= commit_sec;
      ns_q   <= commit_ns;
      wrap_q <= 1'b0;
    end else begin
      sec_q  <= sec_q + DATA_W'(roll);
      ns_q   <= nxt[DATA_W-1:0];
      wrap_q <= roll & pulse_en;
    end
  end

endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cur_ns,
  input  logic [DATA_W-1:0] cur_sec,
  output logic              commit,
  output logic [DATA_W-1:0] stage_ns,
  output rate_t             rate,
  output logic              pulse_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] snap_sec;

  assign sel    = reg_sel_e'(bus_addr);
  assign commit = bus_wr && (sel == REG_SEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_ns <= '0;
      rate     <= '0;
      pulse_en <= 1'b0;
    end else if (bus_wr) begin
      case (sel)
        REG_NSEC: stage_ns <= bus_wdata;
        REG_RATE: rate     <= rate_t'(bus_wdata);
        REG_CTRL: pulse_en <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_sec   <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (sel)
          REG_NSEC: begin
            bus_rdata <= cur_ns;
            snap_sec  <= cur_sec;
          end
          REG_SEC:  bus_rdata <= snap_sec;
          REG_RATE: bus_rdata <= DATA_W'(rate);
          default:  bus_rdata <= DATA_W'(pulse_en);
        endcase
      end
    end
  end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              FRAC_W     = 32,
  parameter int              NOM_NS     = 8,
  parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic [DATA_W-1:0]   tod_sec,
  output logic [DATA_W-1:0]   tod_nsec,
  output logic [2*DATA_W-1:0] tod_time,
  output logic                wrap_evt
);

  logic              commit;
  logic [DATA_W-1:0] stage_ns;
  rate_t             rate;
  logic              pulse_en;
  logic [DATA_W-1:0] step;

  tod_regs #(.DATA_W(DATA_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cur_ns     (tod_nsec),
    .cur_sec    (tod_sec),
    .commit     (commit),
    .stage_ns   (stage_ns),
    .rate       (rate),
    .pulse_en   (pulse_en),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  tod_frac_step #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .NOM_NS (NOM_NS)
  ) step_i (
    .clk   (clk),
    .rst   (rst),
    .clear (commit),
    .rate  (rate),
    .step  (step)
  );

  tod_core #(
    .DATA_W     (DATA_W),
    .NS_PER_SEC (NS_PER_SEC)
  ) core_i (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .commit_ns  (stage_ns),
    .commit_sec (bus_wdata),
    .step       (step),
    .pulse_en   (pulse_en),
    .sec_q      (tod_sec),
    .ns_q       (tod_nsec),
    .wrap_q     (wrap_evt)
  );

  assign tod_time = {tod_sec, tod_nsec};

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int              DATA_W     = 32,
  parameter longint unsigned NS_PER_SEC = 64'd1000000000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] tod_sec,
  input logic [DATA_W-1:0] tod_nsec,
  input logic              wrap_evt,
  input logic              commit,
  input logic              pulse_en
);

  localparam logic [DATA_W-1:0] LIM = DATA_W'(NS_PER_SEC);

  // R3: a legal nanosecond value never leaves the legal range on its own
  a_r3_ns_below_limit: assert property (@(posedge clk) disable iff (rst)
    (tod_nsec < LIM && !commit) |=> (tod_nsec < LIM));

  // R3: a wrap event comes with a seconds increment
  a_r3_sec_on_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |-> (tod_sec == $past(tod_sec) + 1'b1));

  // R4: the event lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> !wrap_evt);

  // R4: a masked wrap raises no event
  a_r4_masked: assert property (@(posedge clk) disable iff (rst)
    !pulse_en |=> !wrap_evt);

  // R8: a commit loads the written seconds
  a_r8_commit_load: assert property (@(posedge clk) disable iff (rst)
    commit |=> (tod_sec == $past(bus_wdata)));

  // R9: every read is answered on the next edge
  a_r9_read_valid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

endmodule

bind tod_clock tod_clock_chk #(
  .DATA_W     (DATA_W),
  .NS_PER_SEC (NS_PER_SEC)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .tod_sec    (tod_sec),
  .tod_nsec   (tod_nsec),
  .wrap_evt   (wrap_evt),
  .commit     (commit),
  .pulse_en   (pulse_en)
);

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NOM = 8;
  localparam logic [63:0] LIM = 64'd1000000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] tod_sec;
  logic [31:0] tod_nsec;
  logic [63:0] tod_time;
  logic        wrap_evt;

  tod_clock dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tod_sec(tod_sec), .tod_nsec(tod_nsec),
    .tod_time(tod_time), .wrap_evt(wrap_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  int wrap_cnt = 0;
  bit done = 0;

  typedef struct { logic [31:0] val; string tag; } item_t;
  item_t sb_q[$];

  // reference state, from the requirements
  logic [31:0] b_sec = 0, b_ns = 0, snap = 0;
  int unsigned c_edge = 0;
  logic        r_slow = 0;
  logic [30:0] r_mag = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wrap_evt === 1'b1) wrap_cnt++;
    if (bus_rvalid === 1'b1) begin
      if (sb_q.size() == 0) check(64'd1, 64'd0, "R9 unexpected read data");
      else begin
        item_t it;
        it = sb_q.pop_front();
        check({32'd0, bus_rdata}, {32'd0, it.val}, it.tag);
      end
    end
  end

  function automatic logic [63:0] exp_at(input int unsigned e);
    logic [63:0] n, prod, adj, tot;
    n    = 64'(e - c_edge);
    prod = n * 64'(r_mag);
    adj  = r_slow ? ((prod + 64'hFFFF_FFFF) >> 32) : (prod >> 32);
    tot  = 64'(b_ns) + n * NOM;
    tot  = r_slow ? tot - adj : tot + adj;
    return {32'(64'(b_sec) + tot / LIM), 32'(tot % LIM)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int unsigned e);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; e = cyc + 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_push(input logic [1:0] a, input logic [31:0] v, input string tag);
    item_t it;
    it.val = v; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_ns(input string tag);
    logic [63:0] t;
    @(negedge clk);
    t = exp_at(cyc);   // value held before the sampling edge cyc+1
    snap = t[63:32];
    rd_push(2'd0, t[31:0], tag);
  endtask

  task automatic rd_sec(input string tag);
    @(negedge clk);
    rd_push(2'd1, snap, tag);
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [31:0] v, input string tag);
    @(negedge clk);
    rd_push(a, v, tag);
  endtask

  task automatic set_rate(input logic slow, input logic [30:0] mag);
    int unsigned e;
    wr(2'd2, {slow, mag}, e);
    r_slow = slow; r_mag = mag;
  endtask

  task automatic set_time(input logic [31:0] s, input logic [31:0] ns);
    int unsigned e;
    wr(2'd0, ns, e);
    wr(2'd1, s, e);
    b_sec = s; b_ns = ns; c_edge = e;
  endtask

  task automatic chk_tod(input string tag);
    logic [63:0] x;
    x = exp_at(cyc);
    check(tod_time, x, tag);
    check({tod_sec, tod_nsec}, x, {tag, " ports"});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tod_time, 64'd0, "R1 time in reset");
    check({63'd0, wrap_evt}, 64'd0, "R1 wrap in reset");
    check({63'd0, bus_rvalid}, 64'd0, "R1 rvalid in reset");
    check({32'd0, bus_rdata}, 64'd0, "R1 rdata in reset");
    rst = 0;
    rd_reg(2'd2, 32'd0, "R1 rate after reset");
    rd_reg(2'd3, 32'd0, "R1 ctrl after reset");

    // R2 nominal advance, R10 export
    set_time(32'd10, 32'd1000);
    chk_tod("R8 commit load");
    idle(1); chk_tod("R2 step 1");
    idle(5); chk_tod("R2 step 6");
    check({32'd0, tod_nsec}, 64'd1000 + 6 * NOM, "R2 closed form");
    // R8 staged nanoseconds have no effect
    wr(2'd0, 32'd777, e);
    chk_tod("R8 stage only");
    idle(3); chk_tod("R8 stage only later");
    rd_ns("R7 nsec read");
    rd_sec("R7 sec snapshot");

    // R3 / R4 wrap with event enabled
    wr(2'd3, 32'd1, e);
    rd_reg(2'd3, 32'd1, "R9 ctrl readback");
    set_time(32'd20, 32'd999999980);
    idle(2);
    chk_tod("R3 before wrap");
    check({63'd0, wrap_evt}, 64'd0, "R4 no early event");
    idle(1);
    check(tod_time, {32'd21, 32'd4}, "R3 rollover");
    check({63'd0, wrap_evt}, 64'd1, "R4 event");
    idle(1);
    check({63'd0, wrap_evt}, 64'd0, "R4 event one cycle");

    // R4 masked
    wr(2'd3, 32'd0, e);
    wrap_cnt = 0;
    set_time(32'd30, 32'd999999980);
    idle(10);
    chk_tod("R4 masked rollover");
    check({32'd0, tod_sec}, 64'd31, "R4 masked seconds");
    check(64'(wrap_cnt), 64'd0, "R4 masked no event");

    // R7 atomic pair across a wrap
    set_time(32'd40, 32'd999999900);
    rd_ns("R7 nsec before wrap");
    idle(20);
    check({32'd0, tod_sec}, 64'd41, "R7 live seconds moved");
    rd_sec("R7 snapshot holds old second");
    rd_ns("R7 nsec after wrap");
    rd_sec("R7 snapshot new second");

    // R5 fast, large magnitude
    set_rate(1'b0, 31'h7FFFFFFF);
    rd_reg(2'd2, 32'h7FFFFFFF, "R9 rate readback");
    set_time(32'd50, 32'd0);
    idle(101); chk_tod("R5 fast max magnitude");
    // R8 commit clears fraction (fraction now non-zero)
    set_time(32'd51, 32'd100);
    chk_tod("R8 recommit");
    idle(1); chk_tod("R8 fraction cleared 1");
    idle(1); chk_tod("R8 fraction cleared 2");
    idle(1); chk_tod("R8 fraction cleared 3");

    // R5 fast, 1/16 ns per cycle
    set_rate(1'b0, 31'h10000000);
    set_time(32'd55, 32'd0);
    idle(64);
    check({32'd0, tod_nsec}, 64'(64 * NOM + 4), "R5 sixteen-cycle carries");

    // R6 slow, largest correction
    set_rate(1'b1, 31'd858993445);
    rd_reg(2'd2, {1'b1, 31'd858993445}, "R9 slow rate readback");
    set_time(32'd60, 32'd5000);
    idle(1); chk_tod("R6 slow first borrow");
    idle(999); chk_tod("R6 slow after 1000");
    rd_ns("R6 nsec read slow");

    // R5 slow near a wrap
    set_time(32'd70, 32'd999999990);
    idle(4); chk_tod("R5 slow rollover");

    idle(3);
    if (sb_q.size() != 0) check(64'(sb_q.size()), 64'd0, "R9 reads unanswered");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule